// File: doc/BRIEF.md
# Dual-Lane Bit Striping Unit

This unit sits between a byte-oriented transfer engine and two flash devices that are wired in parallel and read or written together. On the transmit side it takes a group of bytes, one byte per lane, and spreads their bits across the lanes. Each lane then carries alternate bits of the original data stream. On the receive side it applies the exact inverse to the bytes returned by the lanes, so software sees the original byte order again. Bits are taken most significant bit first, and the bytes of a group are taken in order. The even-position bits go to the lower lane and the odd-position bits go to the upper lane. When only one flash device is in use, the unit passes data through unchanged.

A group enters on a valid/ready stream together with two control bits: the direction and whether both lanes are in use. Both control bits are captured with the data on the accepting handshake. The result appears one cycle later on a registered valid/ready output stream, together with per-lane copies of the output bytes.

Back-pressure rules:
- A group is accepted in any cycle in which both `in_valid` and `in_ready` are high.
- `in_ready` is high when the output register is empty, or when it is being emptied in the same cycle. A full rate of one group per cycle is therefore possible.
- While `out_valid` is high and `out_ready` is low, every output holds its value and no new group is accepted.

Top module: `bit_stripe_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is low.
- R2: A group accepted at a clock edge (`in_valid` and `in_ready` both high) is presented on `out_valid`/`out_data` right after that edge. One register lies on the path.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_lane` stay unchanged.
- R4: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. When `out_valid` falls with no new group, it stays low until the next accepted group.
- R5: Byte element i of a group occupies bits [8i+7:8i]. With `in_dual`=1 and `in_unstripe`=0, output element 0 holds bits 7,5,3,1 of input element 0 followed by bits 7,5,3,1 of input element 1, MSB first. Output element 1 holds bits 6,4,2,0 of element 0 followed by bits 6,4,2,0 of element 1. For example, input {0x0F,0xB4} (element 1, element 0) gives {0x63,0xC3}.
- R6: With `in_dual`=1 and `in_unstripe`=1, the unit applies the inverse of R5. Unstriping a striped group returns the original group.
- R7: With `in_dual`=0, the group passes through unchanged in either direction.
- R8: For a dual group, lane l (`out_lane[8l+7:8l]`) carries output element 1-l. Lane 0 therefore gets the even-bit byte. For a single group, both lanes carry output element 0.
- R9: `in_unstripe` and `in_dual` take effect only on the accepting handshake. Changing them at any other time does not alter a presented group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Unit can accept a group |
| in_data | input | 16 | Input group, element i at [8i+7:8i] |
| in_unstripe | input | 1 | 0 = stripe (transmit), 1 = unstripe (receive) |
| in_dual | input | 1 | 1 = both lanes in use, 0 = single lane (pass-through) |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream accepts the output group |
| out_data | output | 16 | Transformed group, element i at [8i+7:8i] |
| out_lane | output | 16 | Per-lane bytes, lane l at [8l+7:8l] |

## Verification
The checker checks the stream rules on every cycle: idle after reset, one-cycle presentation of an accepted group, the hold of all outputs under back-pressure, and that `in_ready` follows the state of the output register. The bit mapping itself, the inverse relation, single-lane pass-through, lane assignment and the capture of the mode bits only at the handshake depend on data values. The bench's directed and random scenarios show these by comparing against its own reference walk over the bits.

// File: rtl/bit_stripe_pkg.sv
package bit_stripe_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    DIR_STRIPE   = 1'b0,
    DIR_UNSTRIPE = 1'b1
  } stripe_dir_e;

  // Position of a bit inside a packed group: element e, bit b.
  function automatic int unsigned bit_pos(input int unsigned e, input int unsigned b,
                                          input int unsigned w);
    return e * w + b;
  endfunction
endpackage

// File: rtl/stripe_core.sv
// Fixed wiring for an N-way column-wise bit interleave, MSB first.
// The k-th bit of the row-wise walk (element k/W, bit W-1-k%W) lands in
// element k%N, bit W-1-k/N. INVERSE swaps source and destination.
module stripe_core #(
  parameter int unsigned N       = 2,
  parameter int unsigned W       = 8,
  parameter bit          INVERSE = 1'b0
) (
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] dout
);
  import bit_stripe_pkg::*;
  localparam int unsigned TOTAL = N * W;

  for (genvar k = 0; k < TOTAL; k++) begin : g_bit
    localparam int unsigned ROW_POS = bit_pos(k / W, W - 1 - (k % W), W);
    localparam int unsigned COL_POS = bit_pos(k % N, W - 1 - (k / N), W);
    if (INVERSE) begin : g_inv
      assign dout[ROW_POS] = din[COL_POS];
    end else begin : g_fwd
      assign dout[COL_POS] = din[ROW_POS];
    end
  end
endmodule

// File: rtl/stage_reg.sv
// Single output register with valid/ready; accepts when empty or draining.
module stage_reg #(
  parameter int unsigned DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign s_ready = !full_q || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (s_ready) begin
      full_q <= s_valid;
      if (s_valid) data_q <= s_data;
    end
  end

  assign m_valid = full_q;
  assign m_data  = data_q;
endmodule

// File: rtl/lane_map.sv
// Output element i drives lane N-1-i when all lanes are in use;
// in single-lane mode every lane repeats element 0.
module lane_map #(
  parameter int unsigned N = 2,
  parameter int unsigned W = 8
) (
  input  logic           dual,
  input  logic [N*W-1:0] group,
  output logic [N*W-1:0] lanes
);
  for (genvar l = 0; l < N; l++) begin : g_lane
    localparam int unsigned SRC = N - 1 - l;
    assign lanes[l*W +: W] = dual ? group[SRC*W +: W] : group[0 +: W];
  end
endmodule

// File: rtl/bit_stripe_unit.sv
module bit_stripe_unit #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = bit_stripe_pkg::BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*BYTE_W-1:0] in_data,
  input  logic                    in_unstripe,
  input  logic                    in_dual,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic [LANES*BYTE_W-1:0] out_lane
);
  import bit_stripe_pkg::*;
  localparam int unsigned GW = LANES * BYTE_W;
  localparam int unsigned SW = GW + 1;

  logic [GW-1:0] striped, unstriped, next_group;
  stripe_dir_e   dir;

  stripe_core #(.N(LANES), .W(BYTE_W), .INVERSE(1'b0)) u_fwd (
    .din (in_data),
    .dout(striped)
  );
  stripe_core #(.N(LANES), .W(BYTE_W), .INVERSE(1'b1)) u_inv (
    .din (in_data),
    .dout(unstriped)
  );

  assign dir = stripe_dir_e'(in_unstripe);

  always_comb begin
    if (!in_dual)                 next_group = in_data;
    else if (dir == DIR_UNSTRIPE) next_group = unstriped;
    else                          next_group = striped;
  end

  logic [SW-1:0] held;

  stage_reg #(.DW(SW)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data ({in_dual, next_group}),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (held)
  );

  assign out_data = held[GW-1:0];

  lane_map #(.N(LANES), .W(BYTE_W)) u_lanes (
    .dual (held[GW]),
    .group(held[GW-1:0]),
    .lanes(out_lane)
  );
endmodule

// File: rtl/bit_stripe_unit_chk.sv
module bit_stripe_unit_chk #(
  parameter int unsigned GW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [GW-1:0] out_data,
  input logic [GW-1:0] out_lane
);
  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  a_r2_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R3
  a_r3_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_lane));

  // R4
  a_r4_no_accept_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r4_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r4_drain_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && (!out_valid || out_ready) |=> !out_valid);
endmodule

bind bit_stripe_unit bit_stripe_unit_chk #(.GW(LANES * BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_lane (out_lane)
);

// File: tb/bit_stripe_unit_tb.sv
module bit_stripe_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_unstripe = 1'b0;
  logic        in_dual = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [15:0] out_lane;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bit_stripe_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_unstripe(in_unstripe), .in_dual(in_dual),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_lane(out_lane)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference walk: bits taken element by element, MSB first, written to
  // the next column; column index wraps and then the row bit decrements.
  function automatic logic [15:0] ref_xform(input logic [15:0] x, input bit unst,
                                            input bit dual);
    logic [15:0] r = '0;
    int col = 0;
    int row = 7;
    int n = dual ? 2 : 1;
    if (!dual) return x;
    for (int e = 0; e < n; e++) begin
      for (int b = 7; b >= 0; b--) begin
        if (!unst) r[col*8 + row] = x[e*8 + b];
        else       r[e*8 + b]     = x[col*8 + row];
        col++;
        if (col == n) begin
          col = 0;
          row--;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_lanes(input logic [15:0] g, input bit dual);
    return dual ? {g[7:0], g[15:8]} : {g[7:0], g[7:0]};
  endfunction

  // One group: drive, wait for acceptance, check, stall, drain.
  task automatic xfer(input logic [15:0] d, input bit unst, input bit dual,
                      input int stall, input string req);
    logic [15:0] exp_d = ref_xform(d, unst, dual);
    logic [15:0] exp_l = ref_lanes(exp_d, dual);
    @(negedge clk);
    in_data = d; in_unstripe = unst; in_dual = dual; in_valid = 1'b1;
    out_ready = (stall == 0);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_unstripe = ~unst; in_dual = ~dual; in_data = ~d;   // R9: changes after accept
    check(out_valid, "R2 out_valid", {15'd0, out_valid}, 16'd1);
    check(out_data == exp_d, req, out_data, exp_d);
    check(out_lane == exp_l, "R8 lanes", out_lane, exp_l);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(out_valid && out_data == exp_d, "R3 hold data", out_data, exp_d);
      check(out_lane == exp_l, "R9 mode capture lanes", out_lane, exp_l);
      check(!in_ready, "R4 in_ready low", {15'd0, in_ready}, 16'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R4 drained", {15'd0, out_valid}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 reset idle", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 idle after reset", {15'd0, out_valid}, 16'd0);
    check(in_ready, "R4 ready when empty", {15'd0, in_ready}, 16'd1);

    // R5 literal example, R6 inverse of it
    check(ref_xform(16'h0FB4, 1'b0, 1'b1) == 16'h63C3, "R5 reference",
          ref_xform(16'h0FB4, 1'b0, 1'b1), 16'h63C3);
    xfer(16'h0FB4, 1'b0, 1'b1, 0, "R5 stripe example");
    xfer(16'h63C3, 1'b1, 1'b1, 0, "R6 unstripe example");
    xfer(16'hFFFF, 1'b0, 1'b1, 0, "R5 all ones");
    xfer(16'h0001, 1'b0, 1'b1, 1, "R5 single bit");
    xfer(16'hAAAA, 1'b0, 1'b1, 0, "R5 alternating");
    xfer(16'h1234, 1'b0, 1'b0, 0, "R7 single stripe identity");
    xfer(16'hBEEF, 1'b1, 1'b0, 2, "R7 single unstripe identity");
    xfer(16'hC35A, 1'b0, 1'b1, 3, "R3 stalled stripe");

    // R6 round trip at the ports
    for (int i = 0; i < 20; i++) begin
      logic [15:0] v = 16'($urandom);
      logic [15:0] st = ref_xform(v, 1'b0, 1'b1);
      xfer(v, 1'b0, 1'b1, 0, "R5 random stripe");
      xfer(st, 1'b1, 1'b1, 0, "R6 round trip");
      check(ref_xform(st, 1'b1, 1'b1) == v, "R6 reference inverse",
            ref_xform(st, 1'b1, 1'b1), v);
    end

    // back-to-back full-rate groups: R2
    @(negedge clk);
    out_ready = 1'b1;
    in_dual = 1'b1; in_unstripe = 1'b0; in_data = 16'h0FB4; in_valid = 1'b1;
    @(negedge clk);
    in_data = 16'h63C3; in_unstripe = 1'b1;
    check(out_data == 16'h63C3, "R2 first of pair", out_data, 16'h63C3);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 16'h0FB4, "R2 second of pair", out_data, 16'h0FB4);
    @(negedge clk);
    check(!out_valid, "R4 idle after pair", {15'd0, out_valid}, 16'd0);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      xfer(16'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
           "R5/R6/R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule